// File: doc/BRIEF.md
# Instruction Predecode and Length Unit

This stage sits between a fetch buffer that hands out instructions in 16-bit pieces and the instruction decoder. Each cycle the fetch buffer presents a window: the PC of the next instruction, the halfword at that PC, the halfword after it, and a flag saying whether that second halfword is present yet. The unit looks at the low two bits of the first halfword to decide whether the instruction is a 16-bit compressed one or a full 32-bit one. For a 32-bit instruction it builds the full word from the two halfwords. It also produces the sequential successor PC.

For direct jumps (the 32-bit jump-and-link and the two compressed unconditional jumps), the unit computes the target address. It also works out the link register write: which register gets the successor PC, and whether a write happens at all. A single input says whether compressed instructions are enabled. When they are disabled, a compressed encoding raises an illegal-instruction exception, and a jump target that is not 4-byte aligned raises a misaligned-target exception. Either exception reports the PC of the faulting instruction. For compressed instructions, the unit also expands the two 3-bit register fields into full register numbers.

All outputs are registered and appear one cycle after the window is sampled.

Top module: `ifu_predecode`

## Requirements
- R1: An instruction is 32 bits long when bits [1:0] of the halfword at the PC equal 2'b11. Any other value marks a 16-bit instruction, reported by `out_is_comp`=1.
- R2: A 32-bit instruction is presented as `{win_hi, win_lo}`: the halfword at PC+2 is the upper half and the halfword at PC is the lower half. A 16-bit instruction is presented as `{16'h0, win_lo}`.
- R3: `out_next_pc` is the PC plus 2 for a 16-bit instruction and the PC plus 4 for a 32-bit instruction.
- R4: A 16-bit instruction sampled while `c_ext_en`=0 gives `exc_valid`=1 with `exc_cause`=2 and `exc_tval` equal to its PC.
- R5: A 32-bit instruction whose second halfword is absent (`win_hi_ok`=0) gives `out_valid`=0 and `exc_valid`=0, and raises `out_wait`=1 for that slot.
- R6: Jump detection and targets:
  - A 32-bit jump-and-link (bits [6:0] = 7'b1101111) gives `out_jump`=1 and a target equal to the PC plus its sign-extended 21-bit J-format offset.
  - With `c_ext_en`=1, a compressed jump (bits [1:0]=01, bits [15:13]=101) or a compressed jump-and-link (bits [1:0]=01, bits [15:13]=001) gives a target equal to the PC plus its sign-extended 12-bit offset.
- R7: Misaligned jump targets:
  - With `c_ext_en`=0, a jump whose target has bits [1:0] not equal to zero gives `exc_valid`=1, `exc_cause`=0 and `exc_tval` equal to the jump's PC.
  - With `c_ext_en`=1, no exception is raised for a target that is only 2-byte aligned.
- R8: A valid jump writes a link only when its destination register is not x0. The link write is reported by `out_link_we`, `out_link_rd` and `out_link_val`, where `out_link_val` is the successor PC. The destination register is bits [11:7] for the 32-bit form, x1 for the compressed jump-and-link, and x0 for the compressed jump.
- R9: For a valid 16-bit instruction, `out_creg_a` is 8 plus bits [9:7] and `out_creg_b` is 8 plus bits [4:2]. Both are zero for a 32-bit instruction.
- R10: Outputs take effect exactly one cycle after the window is sampled. Outputs are gated as follows:
  - When `win_valid`=0, or when `out_valid`=0, every payload output (`out_pc`, `out_insn`, `out_is_comp`, `out_next_pc`, `out_jump`, `out_target`, `out_link_*`, `out_creg_*`) is zero.
  - An exception suppresses `out_valid`.
- R11: While `rst_n` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| c_ext_en | input | 1 | Compressed instructions enabled |
| win_valid | input | 1 | Fetch window holds an instruction start |
| win_pc | input | XLEN | PC of the first halfword |
| win_lo | input | 16 | Halfword at PC |
| win_hi | input | 16 | Halfword at PC+2 |
| win_hi_ok | input | 1 | Halfword at PC+2 is present |
| out_valid | output | 1 | Predecoded instruction valid |
| out_pc | output | XLEN | PC of the instruction |
| out_insn | output | 32 | Assembled instruction word |
| out_is_comp | output | 1 | Instruction is 16 bits |
| out_next_pc | output | XLEN | Sequential successor PC |
| out_wait | output | 1 | Waiting for the second halfword |
| out_jump | output | 1 | Direct jump detected |
| out_target | output | XLEN | Jump target |
| out_link_we | output | 1 | Link register write |
| out_link_rd | output | 5 | Link destination register |
| out_link_val | output | XLEN | Link value |
| out_creg_a | output | 5 | Expanded register field from bits [9:7] |
| out_creg_b | output | 5 | Expanded register field from bits [4:2] |
| exc_valid | output | 1 | Exception pulse |
| exc_cause | output | 4 | Exception cause code |
| exc_tval | output | XLEN | Faulting PC |

## Verification
The hardest case to reach is a misaligned jump target. It needs three things in the same slot:
- compressed instructions disabled,
- a 32-bit jump-and-link with its second halfword present,
- a PC and offset whose sum has bit 1 set.

Uniform random words almost never produce this. The stimulus therefore forces the low seven bits of the first halfword to the jump opcode in a large share of cycles, mixes in PCs that are only 2-byte aligned, and switches `c_ext_en` between phases. The same opcode bias, together with randomly withheld second halfwords, also makes jumps that straddle the fetch boundary common, so R5 and R7 are exercised with both settings of `c_ext_en`.

// File: rtl/pd_pkg.sv
package pd_pkg;
    localparam int HW_W    = 16;
    localparam int INSN_W  = 32;
    localparam int CAUSE_W = 4;
    localparam int REG_W   = 5;

    localparam logic [CAUSE_W-1:0] CAUSE_MISALIGN = 4'd0;
    localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL  = 4'd2;

    localparam logic [6:0] OPC_JAL   = 7'b1101111;
    localparam logic [1:0] QUAD_C1   = 2'b01;
    localparam logic [2:0] F3_CJ     = 3'b101;
    localparam logic [2:0] F3_CJAL   = 3'b001;
    localparam logic [REG_W-1:0] REG_RA = 5'd1;
endpackage

// File: rtl/pd_length.sv
module pd_length
    import pd_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0]   pc,
    input  logic [HW_W-1:0]   lo,
    input  logic [HW_W-1:0]   hi,
    input  logic              hi_ok,
    output logic              is_comp,
    output logic              complete,
    output logic [INSN_W-1:0] insn,
    output logic [XLEN-1:0]   next_pc
);
    localparam logic [XLEN-1:0] STEP_C = XLEN'(2);
    localparam logic [XLEN-1:0] STEP_W = XLEN'(4);

    always_comb begin
        is_comp  = (lo[1:0] != 2'b11);
        complete = is_comp || hi_ok;
        insn     = is_comp ? {{HW_W{1'b0}}, lo} : {hi, lo};
        next_pc  = pc + (is_comp ? STEP_C : STEP_W);
    end
endmodule

// File: rtl/pd_jump.sv
module pd_jump
    import pd_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0]   pc,
    input  logic [INSN_W-1:0] insn,
    input  logic              is_comp,
    input  logic              c_en,
    output logic              is_jump,
    output logic [XLEN-1:0]   target,
    output logic [REG_W-1:0]  rd
);
    localparam int JOFF_W = 21;
    localparam int COFF_W = 12;

    logic [JOFF_W-1:0] joff;
    logic [COFF_W-1:0] coff;
    logic              jal32;
    logic              cj;
    logic              cjal;

    always_comb begin
        joff  = {insn[31], insn[19:12], insn[20], insn[30:21], 1'b0};
        coff  = {insn[12], insn[8], insn[10:9], insn[6], insn[7],
                 insn[2], insn[11], insn[5:3], 1'b0};
        jal32 = !is_comp && (insn[6:0] == OPC_JAL);
        cj    = is_comp && c_en && (insn[1:0] == QUAD_C1) && (insn[15:13] == F3_CJ);
        cjal  = is_comp && c_en && (insn[1:0] == QUAD_C1) && (insn[15:13] == F3_CJAL);
        is_jump = jal32 || cj || cjal;
        target  = '0;
        rd      = '0;
        if (jal32) begin
            target = pc + {{(XLEN-JOFF_W){joff[JOFF_W-1]}}, joff};
            rd     = insn[11:7];
        end else if (cj || cjal) begin
            target = pc + {{(XLEN-COFF_W){coff[COFF_W-1]}}, coff};
            rd     = cjal ? REG_RA : '0;
        end
    end
endmodule

// File: rtl/pd_fault.sv
module pd_fault
    import pd_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic               slot_live,
    input  logic               is_comp,
    input  logic               c_en,
    input  logic               is_jump,
    input  logic [1:0]         target_lsb,
    input  logic [XLEN-1:0]    pc,
    output logic               fault,
    output logic [CAUSE_W-1:0] cause,
    output logic [XLEN-1:0]    tval
);
    logic illegal;
    logic misalign;

    always_comb begin
        illegal  = slot_live && is_comp && !c_en;
        misalign = slot_live && !is_comp && is_jump && !c_en && (target_lsb != 2'b00);
        fault    = illegal || misalign;
        cause    = illegal ? CAUSE_ILLEGAL : CAUSE_MISALIGN;
        tval     = fault ? pc : '0;
        if (!fault) cause = '0;
    end
endmodule

// File: rtl/ifu_predecode.sv
module ifu_predecode
    import pd_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               c_ext_en,
    input  logic               win_valid,
    input  logic [XLEN-1:0]    win_pc,
    input  logic [HW_W-1:0]    win_lo,
    input  logic [HW_W-1:0]    win_hi,
    input  logic               win_hi_ok,
    output logic               out_valid,
    output logic [XLEN-1:0]    out_pc,
    output logic [INSN_W-1:0]  out_insn,
    output logic               out_is_comp,
    output logic [XLEN-1:0]    out_next_pc,
    output logic               out_wait,
    output logic               out_jump,
    output logic [XLEN-1:0]    out_target,
    output logic               out_link_we,
    output logic [REG_W-1:0]   out_link_rd,
    output logic [XLEN-1:0]    out_link_val,
    output logic [REG_W-1:0]   out_creg_a,
    output logic [REG_W-1:0]   out_creg_b,
    output logic               exc_valid,
    output logic [CAUSE_W-1:0] exc_cause,
    output logic [XLEN-1:0]    exc_tval
);
    localparam logic [1:0] CREG_HI = 2'b01;

    typedef struct packed {
        logic               valid;
        logic [XLEN-1:0]    pc;
        logic [INSN_W-1:0]  insn;
        logic               is_comp;
        logic [XLEN-1:0]    next_pc;
        logic               wait_hi;
        logic               jump;
        logic [XLEN-1:0]    target;
        logic               link_we;
        logic [REG_W-1:0]   link_rd;
        logic [XLEN-1:0]    link_val;
        logic [REG_W-1:0]   creg_a;
        logic [REG_W-1:0]   creg_b;
        logic               exc;
        logic [CAUSE_W-1:0] cause;
        logic [XLEN-1:0]    tval;
    } pd_state_t;

    pd_state_t state_d, state_q;

    logic              len_comp;
    logic              len_complete;
    logic [INSN_W-1:0] len_insn;
    logic [XLEN-1:0]   len_next;
    logic              jmp_hit;
    logic [XLEN-1:0]   jmp_target;
    logic [REG_W-1:0]  jmp_rd;
    logic              flt_hit;
    logic [CAUSE_W-1:0] flt_cause;
    logic [XLEN-1:0]   flt_tval;
    logic              slot_live;

    assign slot_live = win_valid && len_complete;

    pd_length #(.XLEN(XLEN)) u_length (
        .pc       (win_pc),
        .lo       (win_lo),
        .hi       (win_hi),
        .hi_ok    (win_hi_ok),
        .is_comp  (len_comp),
        .complete (len_complete),
        .insn     (len_insn),
        .next_pc  (len_next)
    );

    pd_jump #(.XLEN(XLEN)) u_jump (
        .pc      (win_pc),
        .insn    (len_insn),
        .is_comp (len_comp),
        .c_en    (c_ext_en),
        .is_jump (jmp_hit),
        .target  (jmp_target),
        .rd      (jmp_rd)
    );

    pd_fault #(.XLEN(XLEN)) u_fault (
        .slot_live  (slot_live),
        .is_comp    (len_comp),
        .c_en       (c_ext_en),
        .is_jump    (jmp_hit),
        .target_lsb (jmp_target[1:0]),
        .pc         (win_pc),
        .fault      (flt_hit),
        .cause      (flt_cause),
        .tval       (flt_tval)
    );

    always_comb begin
        state_d         = '0;
        state_d.wait_hi = win_valid && !len_complete;
        state_d.exc     = flt_hit;
        state_d.cause   = flt_cause;
        state_d.tval    = flt_tval;
        if (slot_live && !flt_hit) begin
            state_d.valid   = 1'b1;
            state_d.pc      = win_pc;
            state_d.insn    = len_insn;
            state_d.is_comp = len_comp;
            state_d.next_pc = len_next;
            state_d.jump    = jmp_hit;
            if (jmp_hit) begin
                state_d.target = jmp_target;
                if (jmp_rd != '0) begin
                    state_d.link_we  = 1'b1;
                    state_d.link_rd  = jmp_rd;
                    state_d.link_val = len_next;
                end
            end
            if (len_comp) begin
                state_d.creg_a = {CREG_HI, win_lo[9:7]};
                state_d.creg_b = {CREG_HI, win_lo[4:2]};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign out_valid    = state_q.valid;
    assign out_pc       = state_q.pc;
    assign out_insn     = state_q.insn;
    assign out_is_comp  = state_q.is_comp;
    assign out_next_pc  = state_q.next_pc;
    assign out_wait     = state_q.wait_hi;
    assign out_jump     = state_q.jump;
    assign out_target   = state_q.target;
    assign out_link_we  = state_q.link_we;
    assign out_link_rd  = state_q.link_rd;
    assign out_link_val = state_q.link_val;
    assign out_creg_a   = state_q.creg_a;
    assign out_creg_b   = state_q.creg_b;
    assign exc_valid    = state_q.exc;
    assign exc_cause    = state_q.cause;
    assign exc_tval     = state_q.tval;

    // R10
    valid_exc_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && exc_valid));

    // R5
    wait_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_wait |-> (!out_valid && !exc_valid));

    // R8
    link_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_link_we |-> (out_valid && out_jump && out_link_rd != '0 && out_link_val == out_next_pc));

    // R3
    succ_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_next_pc - out_pc == (out_is_comp ? XLEN'(2) : XLEN'(4))));

    // R4
    illegal_needs_c_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid && win_lo[1:0] != 2'b11 && !c_ext_en |=> exc_valid && exc_cause == CAUSE_ILLEGAL);

    // R7
    misalign_needs_c_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_ext_en |=> !(exc_valid && exc_cause == CAUSE_MISALIGN));
endmodule

// File: tb/test_ifu_predecode.sv
module test_ifu_predecode;
    localparam int XLEN = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        c_ext_en = 1'b1;
    logic        win_valid = 1'b0;
    logic [31:0] win_pc = '0;
    logic [15:0] win_lo = '0;
    logic [15:0] win_hi = '0;
    logic        win_hi_ok = 1'b0;

    logic        out_valid, out_is_comp, out_wait, out_jump, out_link_we, exc_valid;
    logic [31:0] out_pc, out_insn, out_next_pc, out_target, out_link_val, exc_tval;
    logic [4:0]  out_link_rd, out_creg_a, out_creg_b;
    logic [3:0]  exc_cause;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ifu_predecode #(.XLEN(XLEN)) i_ifu_predecode (
        .clk, .rst_n, .c_ext_en, .win_valid, .win_pc, .win_lo, .win_hi, .win_hi_ok,
        .out_valid, .out_pc, .out_insn, .out_is_comp, .out_next_pc, .out_wait,
        .out_jump, .out_target, .out_link_we, .out_link_rd, .out_link_val,
        .out_creg_a, .out_creg_b, .exc_valid, .exc_cause, .exc_tval
    );

    // expected values for the slot currently on the outputs
    logic        e_valid, e_comp, e_wait, e_jump, e_lwe, e_exc;
    logic [31:0] e_pc, e_insn, e_next, e_tgt, e_lval, e_tval;
    logic [4:0]  e_lrd, e_ca, e_cb;
    logic [3:0]  e_cause;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_clear();
        e_valid = 0; e_comp = 0; e_wait = 0; e_jump = 0; e_lwe = 0; e_exc = 0;
        e_pc = 0; e_insn = 0; e_next = 0; e_tgt = 0; e_lval = 0; e_tval = 0;
        e_lrd = 0; e_ca = 0; e_cb = 0; e_cause = 0;
    endtask

    // behavioural reference, built from the requirement text
    task automatic model();
        logic comp, jmp;
        longint off;
        logic [31:0] word, tgt;
        logic [4:0] dest;
        model_clear();
        if (!win_valid) return;
        comp = (win_lo[1:0] != 2'b11);
        if (!comp && !win_hi_ok) begin e_wait = 1; return; end
        word = comp ? {16'h0, win_lo} : ((32'(win_hi) << 16) | 32'(win_lo));
        jmp = 0; off = 0; dest = 0;
        if (!comp && word[6:0] == 7'h6F) begin
            jmp = 1;
            off = longint'(word[30:21]) * 2 + longint'(word[20]) * 2048
                + longint'(word[19:12]) * 4096 - longint'(word[31]) * 1048576;
            dest = word[11:7];
        end else if (comp && c_ext_en && win_lo[1:0] == 2'b01 &&
                     (win_lo[15:13] == 3'd5 || win_lo[15:13] == 3'd1)) begin
            jmp = 1;
            off = longint'(win_lo[5:3]) * 2 + longint'(win_lo[11]) * 16
                + longint'(win_lo[2]) * 32 + longint'(win_lo[7]) * 64
                + longint'(win_lo[6]) * 128 + longint'(win_lo[10:9]) * 256
                + longint'(win_lo[8]) * 1024 - longint'(win_lo[12]) * 2048;
            dest = (win_lo[15:13] == 3'd1) ? 5'd1 : 5'd0;
        end
        tgt = 32'(longint'(win_pc) + off);
        if (comp && !c_ext_en) begin
            e_exc = 1; e_cause = 4'd2; e_tval = win_pc; return;
        end
        if (jmp && !c_ext_en && tgt[1:0] != 0) begin
            e_exc = 1; e_cause = 4'd0; e_tval = win_pc; return;
        end
        e_valid = 1; e_pc = win_pc; e_insn = word; e_comp = comp;
        e_next = win_pc + (comp ? 32'd2 : 32'd4);
        e_jump = jmp;
        if (jmp) e_tgt = tgt;
        if (jmp && dest != 0) begin e_lwe = 1; e_lrd = dest; e_lval = e_next; end
        if (comp) begin e_ca = 5'd8 + 5'(win_lo[9:7]); e_cb = 5'd8 + 5'(win_lo[4:2]); end
    endtask

    task automatic compare_all();
        chk("R10", "valid", 32'(out_valid), 32'(e_valid));
        chk("R1", "is_comp", 32'(out_is_comp), 32'(e_comp));
        chk("R2", "insn", out_insn, e_insn);
        chk("R10", "pc", out_pc, e_pc);
        chk("R3", "next_pc", out_next_pc, e_next);
        chk("R5", "wait", 32'(out_wait), 32'(e_wait));
        chk("R6", "jump", 32'(out_jump), 32'(e_jump));
        chk("R6", "target", out_target, e_tgt);
        chk("R8", "link_we", 32'(out_link_we), 32'(e_lwe));
        chk("R8", "link_rd", 32'(out_link_rd), 32'(e_lrd));
        chk("R8", "link_val", out_link_val, e_lval);
        chk("R9", "creg_a", 32'(out_creg_a), 32'(e_ca));
        chk("R9", "creg_b", 32'(out_creg_b), 32'(e_cb));
        chk((e_cause == 4'd2) ? "R4" : "R7", "exc_valid", 32'(exc_valid), 32'(e_exc));
        chk((e_cause == 4'd2) ? "R4" : "R7", "exc_cause", 32'(exc_cause), 32'(e_cause));
        chk((e_cause == 4'd2) ? "R4" : "R7", "exc_tval", exc_tval, e_tval);
    endtask

    // drive one slot at a falling edge, then check it one cycle later
    task automatic slot(input logic v, input logic cen, input logic [31:0] pc,
                        input logic [15:0] lo, input logic [15:0] hi, input logic hok);
        win_valid = v; c_ext_en = cen; win_pc = pc; win_lo = lo; win_hi = hi; win_hi_ok = hok;
        model();
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R11: reset state
        model_clear();
        repeat (3) @(negedge clk);
        win_valid = 1; win_lo = 16'h0001; win_hi_ok = 1;
        @(negedge clk);
        compare_all();
        rst_n = 1'b1;
        // directed cases
        slot(1, 1, 32'h100, 16'h0093, 16'h0010, 1);   // R2 32-bit addi
        slot(1, 1, 32'h104, 16'h4585, 16'h0000, 0);   // R1 compressed
        slot(1, 1, 32'h106, 16'h00EF, 16'h0020, 0);   // R5 straddle
        slot(1, 1, 32'h106, 16'h00EF, 16'h0020, 1);   // R6 jal target pc+2, C on: R7 no fault
        slot(1, 0, 32'h100, 16'h00EF, 16'h0020, 1);   // R7 misaligned with C off
        slot(1, 0, 32'h100, 16'h006F, 16'h0040, 1);   // R8 jal x0, aligned
        slot(1, 0, 32'h200, 16'h4585, 16'h0000, 1);   // R4 illegal compressed
        slot(1, 1, 32'h300, 16'hA011, 16'h0000, 1);   // R6 c.j forward
        slot(1, 1, 32'h300, 16'h3FFD, 16'h0000, 1);   // R8 c.jal backward, rd=x1
        slot(1, 1, 32'h310, 16'h8F89, 16'h0000, 1);   // R9 register fields
        slot(0, 1, 32'h400, 16'h00EF, 16'h0020, 1);   // R10 no window
        // randomized phases
        for (int ph = 0; ph < 4; ph++) begin
            for (int n = 0; n < 1500; n++) begin
                logic [15:0] lo;
                logic [31:0] pc;
                lo = 16'($urandom);
                if ($urandom_range(0, 2) == 0) lo[6:0] = 7'h6F;
                else if ($urandom_range(0, 3) == 0) begin lo[1:0] = 2'b01; lo[13] = 1'b1; end
                pc = $urandom & 32'hFFFF_FFFE;
                if ($urandom_range(0, 1) == 0) pc[1] = 1'b0;
                slot($urandom_range(0, 9) != 0, ph[0], pc, lo, 16'($urandom),
                     $urandom_range(0, 3) != 0);
            end
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule